// File: doc/BRIEF.md
# Gated Forwarded-Clock Link Transmitter

This block is the producer end of a short point-to-point link between two adjacent tiles that run from unrelated local clocks. It takes words from a local source and sends them to the neighbour as a registered data word with a registered valid bit. It also sends a forwarded clock that the neighbour uses to capture them. A hold signal comes back from the neighbour when its receive buffer cannot take more words. The transmitter then stops sending, keeps the word it has already accepted, and resumes when hold is released.

The forwarded clock does not run all the time. A configured gating policy sets which local clock edges are passed on. In the sparse policy, pulses appear only for valid words. In the padded policy, each burst gets one extra pulse before it and one after it. In the free-running policy, every edge is forwarded. The padded and free-running policies allow more skew between the data and clock wires, so the block comes out of reset in the padded policy. Each word waits one cycle in a staging register, so the gate knows one cycle ahead when a word will go out. The gate enable is computed from registers and applied through a latch so the forwarded clock cannot glitch. A new policy is taken only while the link is completely idle.

Top module: `link_tx`

## Requirements
- R1: After reset, `tx_valid_o` is low, `src_ready_o` is high, no forwarded clock pulse appears, and the padded policy is in force.
- R2: Policy code 2'b00 (sparse): the forwarded clock pulses at local edge n exactly when `tx_valid_o` was high in the cycle before edge n. That pulse captures that word.
- R3: Policy code 2'b01 (padded): the forwarded clock pulses at edge n exactly when `tx_valid_o` is high in cycle n-2, n-1 or n (cycle k being the cycle after edge k). This gives one lead pulse and one tail pulse per burst. When two bursts are separated by a single idle cycle, the pulses run on without a break.
- R4: Policy codes 2'b10 and 2'b11 (free-running): the forwarded clock pulses at every local edge.
- R5: Without hold, a word accepted at edge k (`src_valid_i` and `src_ready_o` high) is driven on `tx_data_o` with `tx_valid_o` high in the cycle after edge k+1. Back-to-back words flow at one per cycle.
- R6: Words leave in the order they were accepted, with none lost or duplicated.
- R7: If `hold_i` is high at edge n, `tx_valid_o` is low in cycle n. An accepted word that has not been sent is kept until hold falls, and `src_ready_o` is low only while hold is high and such a word is waiting.
- R8: `mode_i` is sampled only at edges where no word is staged or being sent and no tail pulse is still due. At any other edge a change on `mode_i` has no effect on the forwarded clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Local tile clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Gating policy: 00 sparse, 01 padded, 1x free-running |
| src_valid_i | input | 1 | Source offers a word |
| src_data_i | input | DATA_W | Offered word |
| src_ready_o | output | 1 | Transmitter takes the offered word at this edge |
| hold_i | input | 1 | Back-pressure from the neighbour's receive buffer |
| tx_data_o | output | DATA_W | Registered outgoing word |
| tx_valid_o | output | 1 | Registered outgoing valid |
| tx_clk_o | output | 1 | Gated forwarded clock |

## Verification
The bench runs every burst length from one to four against every gap from zero to three in each policy, once without hold and once with a hold pattern. For each edge, it works out the expected pulse from the valid history it has observed. A design with a missing lead pulse, a missing tail pulse, or pulses that stop inside a one-cycle gap would show a clock pulse off by one edge, or a missing pulse just before a word or just after a burst. Under hold, a design that lets valid through, drops the waiting word or sends it twice would break the sequence-number scoreboard. Changing the policy in the middle of a burst checks that a design which samples `mode_i` at the wrong time does not start pulsing idle cycles in the sparse policy.

// File: rtl/link_tx_pkg.sv
package link_tx_pkg;

    // Gating policy codes; both upper codes forward every edge
    typedef enum logic [1:0] {
        GATE_SPARSE = 2'b00,
        GATE_PADDED = 2'b01,
        GATE_FREE   = 2'b10,
        GATE_FREE_X = 2'b11
    } gate_mode_e;

endpackage

// File: rtl/link_tx_pipe.sv
module link_tx_pipe #(
    parameter int DATA_W = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              src_valid_i,
    input  logic [DATA_W-1:0] src_data_i,
    output logic              src_ready_o,
    input  logic              hold_i,
    output logic              stage_valid_o,
    output logic              ahead_o,
    output logic              out_valid_o,
    output logic [DATA_W-1:0] out_data_o
);

    typedef struct packed {
        logic              stg_v;
        logic [DATA_W-1:0] stg_d;
        logic              out_v;
        logic [DATA_W-1:0] out_d;
    } pipe_t;

    pipe_t st_d, st_q;
    logic  take;

    // Staging slot frees whenever it moves out, so only hold plus a waiting word blocks
    assign src_ready_o = !st_q.stg_v || !hold_i;
    assign take        = src_valid_i && src_ready_o;

    always_comb begin
        st_d = st_q;
        if (hold_i) begin
            st_d.out_v = 1'b0;
            if (take) begin
                st_d.stg_v = 1'b1;
                st_d.stg_d = src_data_i;
            end
        end else begin
            st_d.out_v = st_q.stg_v;
            if (st_q.stg_v) begin
                st_d.out_d = st_q.stg_d;
            end
            st_d.stg_v = take;
            if (take) begin
                st_d.stg_d = src_data_i;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stage_valid_o = st_q.stg_v;
    assign ahead_o       = st_q.stg_v && !hold_i;
    assign out_valid_o   = st_q.out_v;
    assign out_data_o    = st_q.out_d;

    // R7: a hold seen at an edge blanks valid for the following cycle
    a_r7_hold_blanks: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hold_i |=> !out_valid_o);

    // R7: a waiting word survives hold unchanged
    a_r7_word_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hold_i && st_q.stg_v) |=> (st_q.stg_v && $stable(st_q.stg_d)));

    // R5: a staged word moves to the outputs at the next free edge
    a_r5_staged_sent: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!hold_i && st_q.stg_v) |=> (out_valid_o && out_data_o == $past(st_q.stg_d)));

endmodule

// File: rtl/link_tx_gate_ctrl.sv
module link_tx_gate_ctrl
    import link_tx_pkg::*;
#(
    parameter gate_mode_e RESET_MODE = GATE_PADDED
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic [1:0] mode_i,
    input  logic       stage_valid_i,
    input  logic       ahead_i,
    input  logic       out_valid_i,
    output logic       clk_en_o
);

    typedef struct packed {
        gate_mode_e mode;
        logic       tail;
    } gate_t;

    gate_t      st_d, st_q;
    gate_mode_e cur_mode;
    logic       idle;

    assign cur_mode = st_q.mode;
    assign idle     = !stage_valid_i && !out_valid_i && !st_q.tail;

    always_comb begin
        st_d      = st_q;
        st_d.tail = out_valid_i;
        if (idle) begin
            st_d.mode = gate_mode_e'(mode_i);
        end
        // Enable for the next forwarded edge, from registered state only
        unique case (st_q.mode)
            GATE_SPARSE: clk_en_o = out_valid_i;
            GATE_PADDED: clk_en_o = ahead_i || out_valid_i || st_q.tail;
            default:     clk_en_o = 1'b1;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{mode: RESET_MODE, tail: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    // R8: the policy cannot move while anything is in flight
    a_r8_mode_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stage_valid_i || out_valid_i) |=> $stable(cur_mode));

    // R3: a tail pulse always follows the last word in the padded policy
    a_r3_tail_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cur_mode == GATE_PADDED && $past(out_valid_i)) |-> clk_en_o);

endmodule

// File: rtl/link_tx_clk_gate.sv
module link_tx_clk_gate (
    input  logic clk_i,
    input  logic en_i,
    output logic gclk_o
);

    logic en_lat;

    // Enable may only change while the clock is low
    always_latch begin
        if (!clk_i) begin
            en_lat = en_i;
        end
    end

    assign gclk_o = clk_i & en_lat;

endmodule

// File: rtl/link_tx.sv
module link_tx
    import link_tx_pkg::*;
#(
    parameter int         DATA_W     = 16,
    parameter gate_mode_e RESET_MODE = GATE_PADDED
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [1:0]        mode_i,
    input  logic              src_valid_i,
    input  logic [DATA_W-1:0] src_data_i,
    output logic              src_ready_o,
    input  logic              hold_i,
    output logic [DATA_W-1:0] tx_data_o,
    output logic              tx_valid_o,
    output logic              tx_clk_o
);

    logic stage_valid;
    logic ahead;
    logic clk_en;

    link_tx_pipe #(.DATA_W(DATA_W)) u_pipe (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .src_valid_i  (src_valid_i),
        .src_data_i   (src_data_i),
        .src_ready_o  (src_ready_o),
        .hold_i       (hold_i),
        .stage_valid_o(stage_valid),
        .ahead_o      (ahead),
        .out_valid_o  (tx_valid_o),
        .out_data_o   (tx_data_o)
    );

    link_tx_gate_ctrl #(.RESET_MODE(RESET_MODE)) u_ctrl (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .mode_i       (mode_i),
        .stage_valid_i(stage_valid),
        .ahead_i      (ahead),
        .out_valid_i  (tx_valid_o),
        .clk_en_o     (clk_en)
    );

    link_tx_clk_gate u_gate (
        .clk_i (clk_i),
        .en_i  (clk_en),
        .gclk_o(tx_clk_o)
    );

endmodule

// File: tb/link_tx_tb.sv
module link_tx_tb;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [1:0]   mode_i = 2'b01;
    logic         src_valid_i = 1'b0;
    logic [W-1:0] src_data_i = '0;
    logic         src_ready_o;
    logic         hold_i = 1'b0;
    logic [W-1:0] tx_data_o;
    logic         tx_valid_o;
    logic         tx_clk_o;

    always #10 clk = ~clk;

    link_tx #(.DATA_W(W)) u_dut (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .mode_i     (mode_i),
        .src_valid_i(src_valid_i),
        .src_data_i (src_data_i),
        .src_ready_o(src_ready_o),
        .hold_i     (hold_i),
        .tx_data_o  (tx_data_o),
        .tx_valid_o (tx_valid_o),
        .tx_clk_o   (tx_clk_o)
    );

    int   checks = 0;
    int   fails = 0;
    int   ncyc = 0;
    int   seq = 0;
    int   acc_cnt = 0;
    int   out_cnt = 0;
    int   hcnt = 0;
    int   skip = 0;
    int   exp_mode = 1;
    bit   acc = 1'b0;
    bit   mon_on = 1'b0;
    bit   hold_pass = 1'b0;
    bit   busy_chg = 1'b0;
    bit   vh [0:8191];
    int   acc_edge [0:4095];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    // Monitor: samples mid high phase, after each edge
    always @(posedge clk) begin
        #5;
        if (mon_on && ncyc < 8190) begin
            bit v, g, eg;
            v = tx_valid_o;
            g = tx_clk_o;
            vh[ncyc] = v;
            if (acc && acc_cnt < 4096) begin
                acc_edge[acc_cnt] = ncyc;
                acc_cnt++;
            end
            if (hold_i) chk(!v, "R7 valid low after hold edge", int'(v), 0);
            if (v) begin
                chk(tx_data_o == W'(out_cnt), "R6 word order", int'(tx_data_o), out_cnt);
                if (!hold_pass && out_cnt < acc_cnt)
                    chk(ncyc - acc_edge[out_cnt] == 1, "R5 latency",
                        ncyc - acc_edge[out_cnt], 1);
                out_cnt++;
            end
            if (skip > 0) begin
                skip--;
            end else if (ncyc >= 2) begin
                case (exp_mode)
                    0:       eg = vh[ncyc-1];
                    1:       eg = vh[ncyc-2] | vh[ncyc-1] | v;
                    default: eg = 1'b1;
                endcase
                if (busy_chg)          chk(g == eg, "R8 busy mode change ignored", int'(g), int'(eg));
                else if (exp_mode == 0) chk(g == eg, "R2 sparse gate", int'(g), int'(eg));
                else if (exp_mode == 1) chk(g == eg, "R3 padded gate", int'(g), int'(eg));
                else                    chk(g == eg, "R4 free-running gate", int'(g), int'(eg));
            end
            ncyc++;
        end
    end

    function automatic bit hpat();
        return hold_pass && ((hcnt % 5) == 3 || (hcnt % 7) == 0);
    endfunction

    task automatic step(input bit sv, input bit hd);
        @(negedge clk);
        src_valid_i = sv;
        src_data_i  = W'(seq);
        hold_i      = hd;
        hcnt++;
        #1;
        acc = sv && src_ready_o;
        if (sv && hd && !src_ready_o) checks++; // R7: refusal only under hold
        if (!hd) chk(src_ready_o, "R7 ready without hold", int'(src_ready_o), 1);
        if (acc) seq++;
    endtask

    task automatic idle(input int k);
        for (int i = 0; i < k; i++) step(1'b0, 1'b0);
    endtask

    task automatic burst(input int len, input int gap);
        int sent;
        sent = 0;
        while (sent < len) begin
            step(1'b1, hpat());
            if (acc) sent++;
        end
        for (int i = 0; i < gap; i++) step(1'b0, hpat());
    endtask

    task automatic set_mode(input int m);
        idle(4);
        @(negedge clk);
        mode_i      = 2'(m);
        exp_mode    = m;
        skip        = 2;
        src_valid_i = 1'b0;
        hold_i      = 1'b0;
        acc         = 1'b0;
        idle(3);
    endtask

    task automatic sweep();
        for (int hp = 0; hp < 2; hp++) begin
            hold_pass = hp[0];
            for (int l = 1; l <= 4; l++)
                for (int gp = 0; gp <= 3; gp++)
                    burst(l, gp);
            hold_pass = 1'b0;
            idle(4);
        end
    endtask

    initial begin
        #(20 * 100000);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", ncyc, 0);
        summary();
        $finish;
    end

    initial begin
        repeat (2) @(posedge clk);
        #5;
        chk(tx_clk_o == 1'b0, "R1 no pulse in reset", int'(tx_clk_o), 0);
        chk(tx_valid_o == 1'b0, "R1 valid low in reset", int'(tx_valid_o), 0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(src_ready_o == 1'b1, "R1 ready after reset", int'(src_ready_o), 1);
        mon_on = 1'b1;
        idle(3);

        // R1: default policy is padded; mode_i was held at 01 so the sweep checks it
        sweep();
        set_mode(0);
        sweep();

        // R8: policy change offered while words are in flight, sparse must persist
        busy_chg = 1'b1;
        for (int i = 0; i < 6; i++) begin
            step(1'b1, 1'b0);
            if (i == 1) mode_i = 2'b10;
            if (i == 4) mode_i = 2'b00;
        end
        idle(5);
        busy_chg = 1'b0;

        set_mode(2);
        sweep();
        set_mode(3);
        burst(2, 0);
        burst(3, 1);
        idle(4);
        set_mode(1);
        burst(3, 1);
        burst(3, 1);
        idle(5);

        chk(out_cnt == acc_cnt, "R6 all words delivered", out_cnt, acc_cnt);
        chk(acc_cnt == seq, "R6 accepted count", acc_cnt, seq);
        summary();
        $finish;
    end

endmodule